// File: doc/BRIEF.md
# Indirect Dword Register Access Window

This block puts a small register space behind two doors. The first door is an 8-byte capability in configuration space. It holds a select byte and a data dword. The data dword mirrors the register-space dword at byte address select × 4. Writing the data dword sends the whole dword into the register space. Every write that touches the capability then refreshes the mirror from whichever dword is currently selected. The second door is a direct port. It reads and writes 1 to 4 little-endian bytes at any byte address, with bounds checking against the size of the register space.

Both doors share one byte-lane port into the register space. The register space itself lies outside the block. It reads combinationally: each lane returns the byte at the port address plus the lane number. A direct access wins the shared port in any cycle in which it is present. The capability's forward and refresh steps use the port only in cycles without a direct access.

Configuration reads return their data through a registered valid pulse. A read of the capability issued while a forward/refresh sequence is running is held back until the refresh lands, so the value it returns is the refreshed one.

Top module: `dword_window`

## Requirements
- R1: After reset the select byte is 0 and the block refreshes the mirror once, so the data dword reads the register-space dword at address 0.
- R2: Capability dword 0 (config dword index CAP_DW) reads as {flags byte = 0, select byte, 16-bit header parameter} from byte 3 down to byte 0. Writes to the header bytes and to the flags byte are ignored. Capability dword 1 (index CAP_DW+1) is the data dword.
- R3: The select byte (dword 0, byte lane 2) and all four bytes of the data dword are writable. Byte-enable bit i writes byte i.
- R4: A write that enables any byte of the data dword merges those bytes into the data dword. It then forwards the full 32-bit result as a four-lane write at register-space byte address select × 4. Without direct traffic, this happens in the cycle after the configuration write.
- R5: Any configuration write with a non-zero byte enable to either capability dword is followed by a read of register-space address select × 4, and the data dword takes that value. The read comes one cycle after the forward, or in the very next cycle when nothing is forwarded.
- R6: When no sequence is running, a configuration read raises cfg_rvalid with its data one cycle after the request. A read issued during a sequence is answered in the cycle the refresh completes, with the refreshed value.
- R7: A configuration write outside the two capability dwords causes no register-space access and leaves the mirror unchanged. A configuration read outside them returns 0.
- R8: A direct access covers size code + 1 bytes (codes 0 to 3 give 1 to 4 bytes), little-endian. Byte i of the write or read data maps to byte address dir_addr + i. Read data is valid in the same cycle as the request.
- R9: The register space spans HDR_BYTES + 4 × NSLOTS bytes (160 by default). Bytes at or beyond that limit are never written and read as 0, so an access running past the end is cut short. An access that starts beyond the end does nothing.
- R10: When select × 4 lies beyond the register space, a data write is not forwarded and the mirror reads 0.
- R11: A direct access takes the shared port. A pending forward or refresh step waits for the next cycle without a direct access. A direct write to the selected dword does not refresh the mirror.
- R12: A capability write that arrives during a sequence updates its bytes at once. Any forward not yet issued stays pending. The sequence then forwards (if pending) and refreshes using the current select and data values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Configuration access request |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | CFG_AW | Configuration dword index |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rvalid | output | 1 | Read response valid pulse |
| cfg_rdata | output | 32 | Read response data |
| dir_req | input | 1 | Direct register-space access request |
| dir_we | input | 1 | 1 = write, 0 = read |
| dir_addr | input | DIR_AW | Direct byte address |
| dir_size | input | 2 | Access size minus one |
| dir_wdata | input | 32 | Direct write data, little-endian |
| dir_rdata | output | 32 | Direct read data, same cycle |
| rs_wr | output | 1 | Register-space write strobe |
| rs_rd | output | 1 | Register-space read strobe |
| rs_addr | output | RS_AW | Byte address of lane 0 |
| rs_be | output | 4 | Lane enables, lane i at rs_addr + i |
| rs_wdata | output | 32 | Register-space write data |
| rs_rdata | input | 32 | Register-space read data, combinational |

## Verification
The in-RTL assertions check four things on every cycle: no lane ever reaches past the end of the register space, the refresh follows the forward, read responses appear only for requested reads, and writes outside the capability leave the mirror alone. They also check that a direct access owns the port address and that a direct read starting beyond the end returns zero. Only the bench scenarios can show the data itself. That covers the merge of partial data writes, the little-endian lane mapping of unaligned direct accesses, and the refreshed value returned by a read held during a sequence. It also covers the ordering when a direct access or a second capability write lands in the middle of a forward and refresh.

// File: rtl/dw_pkg.sv
package dw_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_FWD  = 2'd1,
      SEQ_REF  = 2'd2
   } seq_e;

   function automatic logic [31:0] lane_mask(input logic [31:0] d, input logic [3:0] en);
      logic [31:0] r;
      for (int i = 0; i < 4; i++) r[8*i +: 8] = en[i] ? d[8*i +: 8] : 8'h00;
      return r;
   endfunction

   function automatic logic [31:0] byte_merge(input logic [31:0] old_v, input logic [31:0] new_v,
                                              input logic [3:0] en);
      logic [31:0] r;
      for (int i = 0; i < 4; i++) r[8*i +: 8] = en[i] ? new_v[8*i +: 8] : old_v[8*i +: 8];
      return r;
   endfunction

endpackage

// File: rtl/dw_lane_clip.sv
module dw_lane_clip #(
   parameter int AW    = 12,
   parameter int LIMIT = 160
) (
   input  logic [AW-1:0] addr,
   input  logic [1:0]    size_m1,
   output logic [3:0]    lane_ok
);
   localparam logic [AW:0] LIM = (AW+1)'(LIMIT);

   initial begin
      assert (LIMIT > 0 && LIMIT < (1 << AW))
         else $error("dw_lane_clip: LIMIT must fit in AW bits");
   end

   for (genvar gi = 0; gi < 4; gi++) begin : g_lane
      assign lane_ok[gi] = (2'(gi) <= size_m1) &&
                           (({1'b0, addr} + (AW+1)'(gi)) < LIM);
   end

endmodule

// File: rtl/dw_cap_regs.sv
module dw_cap_regs
   import dw_pkg::*;
#(
   parameter int          CFG_AW  = 6,
   parameter int          CAP_DW  = 16,
   parameter logic [15:0] CAP_HDR = 16'h000C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_req,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [3:0]        cfg_be,
   input  logic [31:0]       cfg_wdata,
   output logic              cfg_rvalid,
   output logic [31:0]       cfg_rdata,
   output logic              win_wr,
   output logic              win_rd,
   output logic [9:0]        win_addr,
   output logic [31:0]       win_wdata,
   input  logic              win_go,
   input  logic [31:0]       ref_data
);
   localparam logic [CFG_AW-1:0] DW_CTL = CFG_AW'(CAP_DW);
   localparam logic [CFG_AW-1:0] DW_DAT = CFG_AW'(CAP_DW + 1);

   seq_e              st_q, st_d;
   logic [7:0]        sel_q, sel_d;
   logic [31:0]       data_q, data_cap, data_d;
   logic              pend_q, pend_d;
   logic [CFG_AW-1:0] rda_q, rda_use;
   logic              hit_ctl, hit_dat, cap_wr, dat_wr, rd_new;
   logic              fwd_go, ref_go, fire;

   function automatic logic [31:0] view(input logic [CFG_AW-1:0] a, input logic [7:0] s,
                                        input logic [31:0] d);
      if (a == DW_CTL)      return {8'h00, s, CAP_HDR};
      else if (a == DW_DAT) return d;
      else                  return 32'h0;
   endfunction

   assign hit_ctl = (cfg_addr == DW_CTL);
   assign hit_dat = (cfg_addr == DW_DAT);
   assign cap_wr  = cfg_req && cfg_we && (hit_ctl || hit_dat) && (cfg_be != 4'h0);
   assign dat_wr  = cfg_req && cfg_we && hit_dat && (cfg_be != 4'h0);
   assign rd_new  = cfg_req && !cfg_we;
   assign fwd_go  = (st_q == SEQ_FWD) && win_go;
   assign ref_go  = (st_q == SEQ_REF) && win_go;

   assign data_cap = ref_go ? ref_data : data_q;
   assign data_d   = dat_wr ? byte_merge(data_cap, cfg_wdata, cfg_be) : data_cap;
   assign sel_d    = (cap_wr && hit_ctl && cfg_be[2]) ? cfg_wdata[23:16] : sel_q;

   always_comb begin
      st_d = st_q;
      if (cap_wr) begin
         st_d = (dat_wr || ((st_q == SEQ_FWD) && !win_go)) ? SEQ_FWD : SEQ_REF;
      end else begin
         case (st_q)
            SEQ_FWD: st_d = win_go ? SEQ_REF : SEQ_FWD;
            SEQ_REF: st_d = win_go ? SEQ_IDLE : SEQ_REF;
            default: st_d = SEQ_IDLE;
         endcase
      end
   end

   assign fire    = rd_new ? ((st_q == SEQ_IDLE) || ref_go) : (pend_q && ref_go && !cap_wr);
   assign pend_d  = rd_new ? !fire : (pend_q && !fire);
   assign rda_use = rd_new ? cfg_addr : rda_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= SEQ_REF;
         sel_q      <= 8'h00;
         data_q     <= 32'h0;
         pend_q     <= 1'b0;
         rda_q      <= '0;
         cfg_rvalid <= 1'b0;
         cfg_rdata  <= 32'h0;
      end else begin
         st_q       <= st_d;
         sel_q      <= sel_d;
         data_q     <= data_d;
         pend_q     <= pend_d;
         if (rd_new) rda_q <= cfg_addr;
         cfg_rvalid <= fire;
         cfg_rdata  <= fire ? view(rda_use, sel_q, data_cap) : 32'h0;
      end
   end

   assign win_wr    = (st_q == SEQ_FWD);
   assign win_rd    = (st_q == SEQ_REF);
   assign win_addr  = {sel_q, 2'b00};
   assign win_wdata = data_q;

   // R5
   ref_after_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && win_go && !cap_wr) |=> (win_rd && !win_wr));

   // R5
   seq_after_capwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_wr |=> (win_wr || win_rd));

   // R6
   rsp_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rvalid |-> $past(rd_new || pend_q));

   // R7
   outside_keeps_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && cfg_we && !hit_ctl && !hit_dat && (st_q == SEQ_IDLE)) |=> $stable(data_q));

   // R4
   fwd_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_go && !cap_wr) |=> !win_wr);

endmodule

// File: rtl/dword_window.sv
module dword_window
   import dw_pkg::*;
#(
   parameter int          NSLOTS    = 31,
   parameter int          HDR_BYTES = 36,
   parameter int          CFG_AW    = 6,
   parameter int          CAP_DW    = 16,
   parameter logic [15:0] CAP_HDR   = 16'h000C,
   parameter int          DIR_AW    = 12,
   parameter int          RS_AW     = $clog2(HDR_BYTES + 4 * NSLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_req,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [3:0]        cfg_be,
   input  logic [31:0]       cfg_wdata,
   output logic              cfg_rvalid,
   output logic [31:0]       cfg_rdata,
   input  logic              dir_req,
   input  logic              dir_we,
   input  logic [DIR_AW-1:0] dir_addr,
   input  logic [1:0]        dir_size,
   input  logic [31:0]       dir_wdata,
   output logic [31:0]       dir_rdata,
   output logic              rs_wr,
   output logic              rs_rd,
   output logic [RS_AW-1:0]  rs_addr,
   output logic [3:0]        rs_be,
   output logic [31:0]       rs_wdata,
   input  logic [31:0]       rs_rdata
);
   localparam int LIMIT = HDR_BYTES + 4 * NSLOTS;

   initial begin
      assert (NSLOTS >= 1 && NSLOTS <= 31) else $error("dword_window: NSLOTS out of range");
      assert (DIR_AW >= 10) else $error("dword_window: DIR_AW must cover select x 4");
      assert (CAP_DW + 1 < (1 << CFG_AW)) else $error("dword_window: capability outside config space");
      assert ((1 << RS_AW) >= LIMIT) else $error("dword_window: RS_AW too small");
   end

   logic              win_wr, win_rd, win_go;
   logic [9:0]        win_addr;
   logic [31:0]       win_wdata, rd_masked;
   logic [DIR_AW-1:0] src_addr;
   logic [1:0]        src_size;
   logic              src_we, src_act;
   logic [3:0]        lanes, lane_act;

   dw_cap_regs #(
      .CFG_AW  (CFG_AW),
      .CAP_DW  (CAP_DW),
      .CAP_HDR (CAP_HDR)
   ) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_req    (cfg_req),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_be     (cfg_be),
      .cfg_wdata  (cfg_wdata),
      .cfg_rvalid (cfg_rvalid),
      .cfg_rdata  (cfg_rdata),
      .win_wr     (win_wr),
      .win_rd     (win_rd),
      .win_addr   (win_addr),
      .win_wdata  (win_wdata),
      .win_go     (win_go),
      .ref_data   (rd_masked)
   );

   assign win_go   = !dir_req;
   assign src_addr = dir_req ? dir_addr : DIR_AW'(win_addr);
   assign src_size = dir_req ? dir_size : 2'd3;
   assign src_we   = dir_req ? dir_we : win_wr;
   assign src_act  = dir_req || win_wr || win_rd;

   dw_lane_clip #(
      .AW    (DIR_AW),
      .LIMIT (LIMIT)
   ) u_clip (
      .addr    (src_addr),
      .size_m1 (src_size),
      .lane_ok (lanes)
   );

   assign lane_act  = src_act ? lanes : 4'h0;
   assign rs_wr     = src_act && src_we && (lane_act != 4'h0);
   assign rs_rd     = src_act && !src_we && (lane_act != 4'h0);
   assign rs_be     = lane_act;
   assign rs_addr   = (lane_act != 4'h0) ? src_addr[RS_AW-1:0] : '0;
   assign rs_wdata  = lane_mask(dir_req ? dir_wdata : win_wdata, src_we ? lane_act : 4'h0);
   assign rd_masked = lane_mask(rs_rdata, src_we ? 4'h0 : lane_act);
   assign dir_rdata = (dir_req && !dir_we) ? rd_masked : 32'h0;

   // R9
   lanes_in_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_wr || rs_rd) |-> (int'(rs_addr) + $countones(rs_be) <= LIMIT));

   // R9
   beyond_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_req && !dir_we && (int'(dir_addr) >= LIMIT)) |-> (dir_rdata == 32'h0));

   // R11
   direct_owns_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_req && (int'(dir_addr) < LIMIT)) |-> (rs_addr == dir_addr[RS_AW-1:0] && rs_be[0]));

   // R8
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rs_wr && rs_rd));

endmodule

// File: tb/sim_dword_window.sv
module sim_dword_window;
   localparam int          NSLOTS = 31;
   localparam int          LIMIT  = 36 + 4 * NSLOTS;
   localparam int          CFG_AW = 6;
   localparam int          CAP_DW = 16;
   localparam int          DIR_AW = 12;
   localparam int          RS_AW  = 8;
   localparam logic [15:0] HDR    = 16'h000C;
   localparam logic [CFG_AW-1:0] A_CTL = CFG_AW'(CAP_DW);
   localparam logic [CFG_AW-1:0] A_DAT = CFG_AW'(CAP_DW + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_req = 0, cfg_we = 0;
   logic [CFG_AW-1:0] cfg_addr = '0;
   logic [3:0] cfg_be = 0;
   logic [31:0] cfg_wdata = 0;
   logic cfg_rvalid;
   logic [31:0] cfg_rdata;
   logic dir_req = 0, dir_we = 0;
   logic [DIR_AW-1:0] dir_addr = '0;
   logic [1:0] dir_size = 0;
   logic [31:0] dir_wdata = 0, dir_rdata;
   logic rs_wr, rs_rd;
   logic [RS_AW-1:0] rs_addr;
   logic [3:0] rs_be;
   logic [31:0] rs_wdata, rs_rdata;

   logic [7:0] mem [LIMIT];
   logic [7:0] exp_mem [LIMIT];
   logic [7:0] sel_m;
   logic [31:0] data_m;
   int n_tests = 0, n_fail = 0;
   logic s1_wr, s1_rd, s2_wr, s2_rd;
   logic [RS_AW-1:0] s1_addr, s2_addr;
   logic [31:0] s1_wdata;

   always #5 clk = ~clk;

   dword_window #(.NSLOTS(NSLOTS), .CFG_AW(CFG_AW), .CAP_DW(CAP_DW), .CAP_HDR(HDR),
                  .DIR_AW(DIR_AW), .RS_AW(RS_AW)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
      .dir_req(dir_req), .dir_we(dir_we), .dir_addr(dir_addr), .dir_size(dir_size),
      .dir_wdata(dir_wdata), .dir_rdata(dir_rdata), .rs_wr(rs_wr), .rs_rd(rs_rd),
      .rs_addr(rs_addr), .rs_be(rs_be), .rs_wdata(rs_wdata), .rs_rdata(rs_rdata));

   always_comb begin
      for (int i = 0; i < 4; i++)
         rs_rdata[8*i +: 8] = (int'(rs_addr) + i < LIMIT) ? mem[int'(rs_addr) + i] : 8'h00;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LIMIT; i++) mem[i] <= 8'(i * 7 + 3);
      end else if (rs_wr) begin
         for (int i = 0; i < 4; i++)
            if (rs_be[i] && int'(rs_addr) + i < LIMIT) mem[int'(rs_addr) + i] <= rs_wdata[8*i +: 8];
      end
   end

   function automatic logic [31:0] exp_dir(input int a, input int sz);
      logic [31:0] r = 32'h0;
      for (int i = 0; i < 4; i++)
         if (i <= sz && a + i < LIMIT) r[8*i +: 8] = exp_mem[a + i];
      return r;
   endfunction

   function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
      logic [31:0] r;
      for (int i = 0; i < 4; i++) r[8*i +: 8] = be[i] ? n[8*i +: 8] : o[8*i +: 8];
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_write(input logic [CFG_AW-1:0] a, input logic [3:0] be, input logic [31:0] d);
      if (a == A_CTL && be[2]) sel_m = d[23:16];
      if (a == A_DAT && be != 0) begin
         data_m = merge(data_m, d, be);
         if (int'(sel_m) * 4 < LIMIT)
            for (int i = 0; i < 4; i++) exp_mem[int'(sel_m) * 4 + i] = data_m[8*i +: 8];
      end
      if ((a == A_CTL || a == A_DAT) && be != 0) data_m = exp_dir(int'(sel_m) * 4, 3);
   endtask

   task automatic cfg_write(input logic [CFG_AW-1:0] a, input logic [3:0] be, input logic [31:0] d);
      cfg_req = 1; cfg_we = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
      @(posedge clk); @(negedge clk);
      cfg_req = 0; cfg_we = 0;
      s1_wr = rs_wr; s1_rd = rs_rd; s1_addr = rs_addr; s1_wdata = rs_wdata;
      @(posedge clk); @(negedge clk);
      s2_wr = rs_wr; s2_rd = rs_rd; s2_addr = rs_addr;
      @(posedge clk); @(negedge clk);
      model_write(a, be, d);
   endtask

   task automatic cfg_read(input logic [CFG_AW-1:0] a, output logic [31:0] d, output int lat);
      cfg_req = 1; cfg_we = 0; cfg_addr = a;
      @(posedge clk); @(negedge clk);
      cfg_req = 0; lat = 1;
      while (!cfg_rvalid && lat < 8) begin
         @(posedge clk); @(negedge clk); lat++;
      end
      d = cfg_rdata;
   endtask

   task automatic dir_access(input logic we, input int a, input int sz, input logic [31:0] wd,
                             output logic [31:0] rd, output logic wr_seen);
      dir_req = 1; dir_we = we; dir_addr = DIR_AW'(a); dir_size = 2'(sz); dir_wdata = wd;
      #1; rd = dir_rdata; wr_seen = rs_wr;
      @(posedge clk); @(negedge clk);
      dir_req = 0; dir_we = 0;
      if (we)
         for (int i = 0; i < 4; i++)
            if (i <= sz && a + i < LIMIT) exp_mem[a + i] = wd[8*i +: 8];
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] rv, fwd;
      logic ws;
      int lat;
      for (int i = 0; i < LIMIT; i++) exp_mem[i] = 8'(i * 7 + 3);
      sel_m = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      data_m = exp_dir(0, 3);
      repeat (3) @(posedge clk);
      @(negedge clk);

      // R1 reset refresh and select
      cfg_read(A_DAT, rv, lat);  chk("R1 mirror of dword 0", rv, exp_dir(0, 3));
      cfg_read(A_CTL, rv, lat);  chk("R1 R2 control dword", rv, {8'h00, 8'h00, HDR});
      chk("R6 idle read latency", 32'(lat), 32'd1);

      // R2 R3 header/flags ignored, select writable
      cfg_write(A_CTL, 4'hF, 32'hFF05AAAA);
      cfg_read(A_CTL, rv, lat);  chk("R2 flags and header fixed", rv, {8'h00, 8'h05, HDR});
      cfg_read(A_DAT, rv, lat);  chk("R5 refresh after select write", rv, exp_dir(20, 3));

      // R4 forward timing, R3 partial byte merge
      fwd = merge(data_m, 32'h00C3_0000 | 32'h0000_5A00, 4'b0010);
      cfg_write(A_DAT, 4'b0010, 32'h0000_5A00);
      chk("R4 forward strobe", {31'h0, s1_wr}, 32'h1);
      chk("R4 forward address", 32'(s1_addr), 32'd20);
      chk("R4 forward full dword", s1_wdata, fwd);
      chk("R5 refresh strobe follows", {31'h0, s2_rd}, 32'h1);
      dir_access(0, 20, 3, 0, rv, ws); chk("R4 register space holds dword", rv, fwd);

      // R6 read during sequence returns refreshed value
      cfg_req = 1; cfg_we = 1; cfg_addr = A_DAT; cfg_be = 4'hF; cfg_wdata = 32'hDEADBEEF;
      @(posedge clk); @(negedge clk);
      cfg_we = 0; model_write(A_DAT, 4'hF, 32'hDEADBEEF);
      @(posedge clk); @(negedge clk);
      cfg_req = 0;
      chk("R6 held read not yet valid", {31'h0, cfg_rvalid}, 32'h0);
      @(posedge clk); @(negedge clk);
      chk("R6 held read valid after refresh", {31'h0, cfg_rvalid}, 32'h1);
      chk("R6 held read data", cfg_rdata, data_m);

      // R7 outside writes/reads
      rv = data_m;
      cfg_write(CFG_AW'(3), 4'hF, 32'h11223344);
      chk("R7 no access after outside write", {30'h0, s1_wr | s1_rd, s2_wr | s2_rd}, 32'h0);
      cfg_read(A_DAT, fwd, lat); chk("R7 mirror unchanged", fwd, rv);
      cfg_read(CFG_AW'(3), fwd, lat); chk("R7 outside read zero", fwd, 32'h0);

      // R8 little-endian, unaligned
      dir_access(1, 49, 1, 32'hAABBCCDD, rv, ws);
      dir_access(0, 48, 3, 0, rv, ws); chk("R8 unaligned 2-byte write", rv, exp_dir(48, 3));
      dir_access(0, 50, 0, 0, rv, ws); chk("R8 single byte read", rv, 32'h000000CC);

      // R9 bounds
      dir_access(0, LIMIT - 2, 3, 0, rv, ws); chk("R9 read cut at end", rv, exp_dir(LIMIT - 2, 1));
      dir_access(1, LIMIT - 1, 3, 32'h99887766, rv, ws);
      dir_access(0, LIMIT - 4, 3, 0, rv, ws); chk("R9 write cut at end", rv, exp_dir(LIMIT - 4, 3));
      dir_access(1, LIMIT, 3, 32'h12345678, rv, ws); chk("R9 beyond write no strobe", {31'h0, ws}, 32'h0);
      dir_access(0, 512, 3, 0, rv, ws); chk("R9 beyond read zero", rv, 32'h0);

      // R10 select beyond space
      cfg_write(A_CTL, 4'b0100, 32'h0028_0000);
      cfg_read(A_DAT, rv, lat); chk("R10 mirror zero", rv, 32'h0);
      cfg_write(A_DAT, 4'hF, 32'h12345678);
      chk("R10 no forward", {31'h0, s1_wr}, 32'h0);
      cfg_read(A_DAT, rv, lat); chk("R10 mirror stays zero", rv, 32'h0);

      // R11 direct priority and no refresh on direct write
      cfg_write(A_CTL, 4'b0100, 32'h0006_0000);
      dir_access(1, 24, 3, 32'hCAFEF00D, rv, ws);
      cfg_read(A_DAT, rv, lat); chk("R11 direct write leaves mirror", rv, data_m);
      cfg_req = 1; cfg_we = 1; cfg_addr = A_DAT; cfg_be = 4'hF; cfg_wdata = 32'h0BADC0DE;
      @(posedge clk); @(negedge clk);
      cfg_req = 0; cfg_we = 0;
      dir_req = 1; dir_we = 0; dir_addr = DIR_AW'(64); dir_size = 2'd3;
      #1;
      chk("R11 direct owns port", {rs_wr, rs_rd, 22'h0, rs_addr}, {2'b01, 22'h0, 8'd64});
      chk("R11 direct data", dir_rdata, exp_dir(64, 3));
      @(posedge clk); @(negedge clk);
      dir_req = 0; #1;
      chk("R11 forward after direct", {rs_wr, 23'h0, rs_addr}, {1'b1, 23'h0, 8'd24});
      @(posedge clk); @(negedge clk);
      chk("R11 refresh after forward", {31'h0, rs_rd}, 32'h1);
      @(posedge clk); @(negedge clk);
      model_write(A_DAT, 4'hF, 32'h0BADC0DE);
      cfg_read(A_DAT, rv, lat); chk("R11 final mirror", rv, data_m);

      // R12 select write during sequence
      cfg_req = 1; cfg_we = 1; cfg_addr = A_DAT; cfg_be = 4'hF; cfg_wdata = 32'h5EED5EED;
      @(posedge clk); @(negedge clk);
      cfg_addr = A_CTL; cfg_be = 4'b0100; cfg_wdata = 32'h0007_0000;
      @(posedge clk); @(negedge clk);
      cfg_req = 0; cfg_we = 0;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      model_write(A_DAT, 4'hF, 32'h5EED5EED);
      model_write(A_CTL, 4'b0100, 32'h0007_0000);
      cfg_read(A_DAT, rv, lat); chk("R12 refresh from new select", rv, exp_dir(28, 3));
      dir_access(0, 24, 3, 0, rv, ws); chk("R12 earlier forward landed", rv, 32'h5EED5EED);

      // random mix
      void'($urandom(32'd1234));
      for (int k = 0; k < 300; k++) begin
         int op = int'($urandom_range(0, 4));
         int a = int'($urandom_range(0, LIMIT + 8));
         int sz = int'($urandom_range(0, 3));
         logic [31:0] d = $urandom;
         logic [3:0] be = 4'($urandom);
         case (op)
            0: dir_access(1, a, sz, d, rv, ws);
            1: begin dir_access(0, a, sz, 0, rv, ws); chk("R8 R9 random direct read", rv, exp_dir(a, sz)); end
            2: cfg_write(A_CTL, be, {d[31:24], 8'($urandom_range(0, 44)), d[15:0]});
            3: cfg_write(A_DAT, be, d);
            default: begin cfg_read(A_DAT, rv, lat); chk("R5 random mirror", rv, data_m);
                     cfg_read(A_CTL, rv, lat); chk("R2 random control", rv, {8'h00, sel_m, HDR}); end
         endcase
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule